// File: doc/BRIEF.md
# Up and Up/Down Period Timer

A 16-bit counter paced by a slow timer-clock level signal and running on a faster system clock. The timer-clock level passes through two synchronizing flip-flops. The counter takes one step for each rising edge that the system clock sees on the synchronized level.

In up mode the counter climbs from zero to a programmable period and then restarts at zero. In up/down mode it climbs to the period and then descends back to zero.

A bus on the system clock writes the period. A write that does not lower the period takes effect at once. A write that lowers the period is held pending, together with the synchronized timer-clock level sampled in the same cycle as the write. If that level was high, the new limit applies at the next timer-clock edge. If it was low, one more step is taken under the old limit first. A counter that already stands at or above the new limit wraps to zero in up mode, or turns downward in up/down mode.

Top module: `updown_period_timer`

## Requirements
- R1: The counter changes only in response to a rising edge of the timer-clock level. The count updates on the third system-clock edge after the level rises. A level that stays high or low causes no further change.
- R2: With `mode` = 0 (up), each timer-clock rising edge adds one to `count`, except that a count at or above the period becomes 0. `dir_down` stays 0.
- R3: With `mode` = 1 (up/down), the count rises by one per edge until it reaches the period. It then falls by one per edge until it reaches 0, and then rises again. `dir_down` is 1 exactly while the count is on its falling leg above zero.
- R4: A period write whose value is greater than or equal to the active period becomes the active period in the next system-clock cycle. It discards any pending smaller value.
- R5: A smaller period written while the synchronized timer-clock level is high is applied at the next timer-clock edge. In up mode the count goes to 0 if it is at or above the new period. In up/down mode the count goes from n to n-1 and `dir_down` becomes 1.
- R6: A smaller period written while the synchronized level is low first allows one more step under the old period. At the following edge the new period applies: in up mode n+1 goes to 0, and in up/down mode n+1 goes to n.
- R7: A count already above a newly applied smaller period never climbs toward the old period. It wraps (up) or turns downward (up/down).
- R8: A second smaller-period write made while one is pending replaces both the pending value and its recorded phase.
- R9: An active period of 0 holds `count` at 0 on every edge.
- R10: `zero_pulse` is high for exactly one system-clock cycle, and only when a timer-clock edge moves the count from a nonzero value to 0.
- R11: Synchronous active-high `rst` sets `count` to 0, `dir_down` to 0 and the period to 0, and clears any pending period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| timer_clk_level | input | 1 | Timer-clock level, asynchronous to `clk` |
| mode | input | 1 | 0 = up, 1 = up/down |
| period_wr | input | 1 | Period write strobe, one `clk` cycle |
| period_wdata | input | 16 | Period value to write |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | 1 while counting down |
| zero_pulse | output | 1 | One-cycle pulse when the count reaches 0 |

## Verification
The step assertions assume that `mode` is held steady while the counter runs. They also assume that each timer-clock level lasts at least a few system-clock cycles, so every edge passes the synchronizer and yields exactly one step. The stimulus holds each level for four system cycles and changes `mode` only during reset. Period writes are placed well inside a level phase, so the synchronized level that records the phase is settled when the strobe is sampled.

// File: rtl/updown_period_timer.sv
module updown_period_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         timer_clk_level,
  input  logic         mode,
  input  logic         period_wr,
  input  logic [W-1:0] period_wdata,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         zero_pulse
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [2:0]   tsync;
  logic         level, tick, adopt;
  logic [W-1:0] period_q, pend_val, limit, nxt_count;
  logic         pend_valid, pend_hi, nxt_dir;

  assign level = tsync[1];
  assign tick  = tsync[1] & ~tsync[2];
  assign adopt = tick & pend_valid & pend_hi;
  assign limit = adopt ? pend_val : period_q;

  always_ff @(posedge clk) begin
    if (rst) tsync <= '0;
    else     tsync <= {tsync[1:0], timer_clk_level};
  end

  always_comb begin
    nxt_count = count;
    nxt_dir   = dir_down;
    if (limit == '0) begin
      nxt_count = '0;
      nxt_dir   = 1'b0;
    end else if (!mode) begin
      nxt_dir   = 1'b0;
      nxt_count = (count >= limit) ? '0 : count + ONE;
    end else if ((dir_down && count != '0) || count >= limit) begin
      nxt_count = count - ONE;
      nxt_dir   = (count != ONE);
    end else begin
      nxt_count = count + ONE;
      nxt_dir   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      dir_down   <= 1'b0;
      zero_pulse <= 1'b0;
    end else if (tick) begin
      count      <= nxt_count;
      dir_down   <= nxt_dir;
      zero_pulse <= (nxt_count == '0) && (count != '0);
    end else begin
      zero_pulse <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q   <= '0;
      pend_val   <= '0;
      pend_valid <= 1'b0;
      pend_hi    <= 1'b0;
    end else begin
      if (tick && pend_valid) begin
        if (pend_hi) begin
          period_q   <= pend_val;
          pend_valid <= 1'b0;
        end else begin
          pend_hi <= 1'b1;
        end
      end
      if (period_wr) begin
        if (period_wdata >= limit) begin
          period_q   <= period_wdata;
          pend_valid <= 1'b0;
        end else begin
          pend_val   <= period_wdata;
          pend_valid <= 1'b1;
          pend_hi    <= level;
        end
      end
    end
  end

endmodule

// File: rtl/updown_period_timer_chk.sv
module updown_period_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         mode,
  input logic         tick,
  input logic [W-1:0] period_q,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         zero_pulse
);

  localparam logic [W-1:0] ONE = W'(1);

  p_hold_without_edge_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick && !mode |=> (count == $past(count) + ONE) || (count == '0));

  p_up_dir_r2: assert property (@(posedge clk) disable iff (rst)
    tick && !mode |=> !dir_down);

  p_ud_step_r3: assert property (@(posedge clk) disable iff (rst)
    tick && mode |=> (count == $past(count) + ONE) || (count == $past(count) - ONE) || (count == '0));

  p_zero_period_r9: assert property (@(posedge clk) disable iff (rst)
    period_q == '0 |-> count == '0);

  p_pulse_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
    zero_pulse |-> count == '0 && !$past(zero_pulse));

  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> count == '0 && !dir_down && !zero_pulse);

endmodule

bind updown_period_timer updown_period_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .tick(tick), .period_q(period_q),
  .count(count), .dir_down(dir_down), .zero_pulse(zero_pulse)
);

// File: tb/tb_updown_period_timer.sv
module tb_updown_period_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        timer_clk_level = 1'b0;
  logic        mode = 1'b0;
  logic        period_wr = 1'b0;
  logic [15:0] period_wdata = '0;
  logic [15:0] count;
  logic        dir_down, zero_pulse;

  int vectors = 0, fails = 0, zp = 0;

  always #5 clk = ~clk;

  updown_period_timer dut (
    .clk(clk), .rst(rst), .timer_clk_level(timer_clk_level), .mode(mode),
    .period_wr(period_wr), .period_wdata(period_wdata),
    .count(count), .dir_down(dir_down), .zero_pulse(zero_pulse)
  );

  always @(negedge clk) if (zero_pulse) zp++;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise();  timer_clk_level = 1'b1; wait_n(4); endtask
  task automatic fall();  timer_clk_level = 1'b0; wait_n(4); endtask
  task automatic tedge(); rise(); fall(); endtask

  task automatic wr(int v);
    period_wr = 1'b1; period_wdata = 16'(v);
    wait_n(1);
    period_wr = 1'b0;
    wait_n(1);
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst = 1'b1; timer_clk_level = 1'b0; period_wr = 1'b0; mode = m;
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
    zp = 0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    check("R11 count", int'(count), 0);
    check("R11 dir", int'(dir_down), 0);
    check("R11 pulse", int'(zero_pulse), 0);
    tedge();
    check("R11 stopped at zero period", int'(count), 0);
  endtask

  task automatic t_up_basic();
    do_reset(1'b0);
    wr(3);
    check("R4 no step from write", int'(count), 0);
    timer_clk_level = 1'b1; wait_n(12);
    check("R1 single step per edge", int'(count), 1);
    fall();
    tedge(); check("R2 step", int'(count), 2);
    tedge(); check("R2 step", int'(count), 3);
    check("R2 dir", int'(dir_down), 0);
    tedge(); check("R2 wrap", int'(count), 0);
    check("R10 one pulse", zp, 1);
    tedge(); check("R2 restart", int'(count), 1);
  endtask

  task automatic t_updown_basic();
    do_reset(1'b1);
    wr(3);
    tedge(); tedge(); tedge();
    check("R3 top", int'(count), 3); check("R3 dir up", int'(dir_down), 0);
    tedge(); check("R3 turn", int'(count), 2); check("R3 dir down", int'(dir_down), 1);
    tedge(); check("R3 fall", int'(count), 1);
    tedge(); check("R3 bottom", int'(count), 0); check("R3 dir at zero", int'(dir_down), 0);
    check("R10 pulse at bottom", zp, 1);
    tedge(); check("R3 rise again", int'(count), 1);
  endtask

  task automatic t_up_high();
    do_reset(1'b0);
    wr(5); tedge(); tedge(); rise();
    check("R5 setup", int'(count), 3);
    wr(2); fall();
    tedge(); check("R5 up high phase wrap", int'(count), 0);
    tedge(); tedge(); check("R5 new top", int'(count), 2);
    tedge(); check("R5 new wrap", int'(count), 0);
  endtask

  task automatic t_up_low();
    do_reset(1'b0);
    wr(5); tedge(); tedge(); tedge();
    wr(2);
    tedge(); check("R6 up one more old step", int'(count), 4);
    tedge(); check("R7 up above new limit wraps", int'(count), 0);
    tedge(); tedge(); tedge(); check("R6 new period used", int'(count), 0);
  endtask

  task automatic t_ud_high();
    do_reset(1'b1);
    wr(5); tedge(); tedge(); rise();
    wr(2); fall();
    tedge(); check("R5 ud n-1", int'(count), 2); check("R5 ud dir", int'(dir_down), 1);
    tedge(); tedge(); check("R5 ud bottom", int'(count), 0);
    tedge(); tedge(); tedge(); check("R5 ud new top turn", int'(count), 1);
  endtask

  task automatic t_ud_low();
    do_reset(1'b1);
    wr(5); tedge(); tedge(); tedge();
    wr(2);
    tedge(); check("R6 ud n+1", int'(count), 4);
    tedge(); check("R7 ud turn from above", int'(count), 3); check("R7 ud dir", int'(dir_down), 1);
    tedge(); tedge(); tedge(); check("R6 ud bottom", int'(count), 0);
    tedge(); tedge(); tedge(); check("R6 ud new top", int'(count), 1);
  endtask

  task automatic t_grow();
    do_reset(1'b0);
    wr(2); tedge();
    wr(4);
    tedge(); tedge(); tedge(); check("R4 larger period reached", int'(count), 4);
    tedge(); check("R4 larger wrap", int'(count), 0);
    wr(4); tedge(); tedge(); tedge(); tedge(); tedge();
    check("R4 equal write no change", int'(count), 0);
  endtask

  task automatic t_replace();
    do_reset(1'b0);
    wr(5); tedge(); tedge(); rise();
    wr(2); fall();
    wr(3);
    tedge(); check("R8 replaced phase old step", int'(count), 4);
    tedge(); check("R8 replaced value applied", int'(count), 0);
    tedge(); tedge(); tedge(); check("R8 period three", int'(count), 3);
  endtask

  task automatic t_zero();
    do_reset(1'b0);
    wr(4); tedge(); tedge();
    wr(0);
    tedge(); check("R9 old step", int'(count), 3);
    tedge(); check("R9 zero", int'(count), 0);
    tedge(); tedge(); check("R9 held", int'(count), 0);
    check("R10 single pulse", zp, 1);
  endtask

  task automatic t_reset_pending();
    do_reset(1'b0);
    wr(5); tedge(); tedge(); tedge();
    wr(2);
    do_reset(1'b0);
    wr(5);
    tedge(); tedge(); tedge(); tedge(); tedge();
    check("R11 pending cleared", int'(count), 5);
  endtask

  bit done = 0;

  initial begin
    t_reset_state();
    t_up_basic();
    t_updown_basic();
    t_up_high();
    t_up_low();
    t_ud_high();
    t_ud_low();
    t_grow();
    t_replace();
    t_zero();
    t_reset_pending();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule